// File: doc/BRIEF.md
# Timer-Based Capture/Compare Unit

This block sits next to a 16-bit free-running timer and uses the timer value as its time base. It holds one capture/compare register. In the capture modes, a selected transition on an input pin (one falling edge, one rising edge, or every fourth or sixteenth rising edge) stores the current timer value in the register. In the compare modes, the unit watches for the timer value becoming equal to the register and raises one event per match.

One compare mode also drives a clear strobe back to the timer. The register then sets the timer's period, and the timer's own overflow interrupt is left alone. Software loads the register through a write port and clears the sticky interrupt flag through a clear input. The pin is assumed to be synchronous to the clock already. The timer must run on the same clock for the clear strobe to be seen reliably.

Top module: `capcmp_top`

## Requirements
- R1: While reset is asserted, `ccr_q` reads 0 and `irq_flag` and `tmr_clr` read 0.
- R2: With `mode` = 1, a high-to-low transition of `cap_pin` between two clock edges stores `timer_val` in `ccr_q` at the edge where the low pin is sampled. It also sets `irq_flag` at that edge.
- R3: With `mode` = 2, every low-to-high transition of `cap_pin` stores `timer_val` and sets `irq_flag` in the same way.
- R4: With `mode` = 3, only every fourth rising edge captures. The count of rising edges starts again whenever `mode` differs from its value at the previous clock edge.
- R5: With `mode` = 4, only every sixteenth rising edge captures, and the count restarts on a mode change in the same way.
- R6: With `mode` = 5 or 6, a clock edge where `timer_val` equals `ccr_q` sets `irq_flag`, provided the two were not equal, or the mode was not a compare mode, at the edge before. A match that is held for several cycles therefore sets the flag only once.
- R7: With `mode` = 6, each match event also makes `tmr_clr` high for exactly one cycle, in the same cycle that `irq_flag` is set. No other mode ever asserts `tmr_clr`.
- R8: `wr_en` loads `wr_data` into `ccr_q` at the next edge in any mode. A write takes precedence over a capture in the same cycle, and the capture still sets `irq_flag`.
- R9: `irq_flag` stays set until `irq_clr` is high at an edge. If a set and a clear fall on the same edge, the flag stays set.
- R10: With `mode` = 0 or 7, pin activity and timer equality have no effect: `ccr_q` changes only by a write, and `tmr_clr` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the timer |
| rst_n | input | 1 | Asynchronous reset, active low |
| timer_val | input | 16 | Current time-base value |
| cap_pin | input | 1 | Capture input, already synchronous |
| mode | input | 3 | Mode select (0 off, 1–4 capture, 5–6 compare, 7 off) |
| wr_en | input | 1 | Software write strobe for the register |
| wr_data | input | 16 | Value to write |
| irq_clr | input | 1 | Clears the interrupt flag |
| ccr_q | output | 16 | Capture/compare register contents |
| irq_flag | output | 1 | Sticky interrupt flag |
| tmr_clr | output | 1 | One-cycle clear strobe to the timer |

## Verification
Two pairs of functions can fall in the same cycle. A software write can meet a capture event, and a flag-setting event (a capture or a match) can meet a flag clear. Directed steps line up a selected pin edge with `wr_en`, and a match with `irq_clr`. The bench's reference model then expects the written value to survive and the flag to stay set.

Random stimulus does the same at a high rate. Frequent writes, frequent clears and a timer that wraps at 64 make these collisions, and matches followed by clears, occur many times.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [2:0] {
    CC_OFF        = 3'd0,
    CC_CAP_FALL   = 3'd1,
    CC_CAP_RISE   = 3'd2,
    CC_CAP_RISE_A = 3'd3,
    CC_CAP_RISE_B = 3'd4,
    CC_CMP        = 3'd5,
    CC_CMP_TRIG   = 3'd6,
    CC_IDLE       = 3'd7
  } cc_mode_e;

  function automatic logic mode_is_compare(input logic [2:0] m);
    return (m == CC_CMP) || (m == CC_CMP_TRIG);
  endfunction

  function automatic logic mode_is_prescaled(input logic [2:0] m);
    return (m == CC_CAP_RISE_A) || (m == CC_CAP_RISE_B);
  endfunction

  // Number of selected edges per capture.
  function automatic int unsigned capture_divisor(input logic [2:0] m,
                                                  input int unsigned div_a,
                                                  input int unsigned div_b);
    if (m == CC_CAP_RISE_A) return div_a;
    if (m == CC_CAP_RISE_B) return div_b;
    return 1;
  endfunction

  // Which pin transition counts for a mode.
  function automatic logic edge_selected(input logic [2:0] m,
                                         input logic rise, input logic fall);
    if (m == CC_CAP_FALL) return fall;
    if (m == CC_CAP_RISE || m == CC_CAP_RISE_A || m == CC_CAP_RISE_B) return rise;
    return 1'b0;
  endfunction

endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge
  import capcmp_pkg::*;
#(
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [2:0] mode,
  output logic       cap_fire
);
  localparam int unsigned CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;

  logic             pin_q;
  logic [2:0]       mode_q;
  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_d;
  logic             rise, fall, sel;
  logic [31:0]      lim;

  assign rise = pin & ~pin_q;
  assign fall = ~pin & pin_q;
  assign sel  = edge_selected(mode, rise, fall);
  assign lim  = capture_divisor(mode, DIV_A, DIV_B) - 1;

  always_comb begin
    cnt_base = (mode != mode_q) ? '0 : cnt_q;
    cnt_d    = '0;
    cap_fire = 1'b0;
    if (!mode_is_prescaled(mode)) begin
      cap_fire = sel;
    end else if (sel) begin
      if ({{(32-CNT_W){1'b0}}, cnt_base} == lim) begin
        cap_fire = 1'b1;
      end else begin
        cnt_d = cnt_base + 1'b1;
      end
    end else begin
      cnt_d = cnt_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      mode_q <= 3'd0;
      cnt_q  <= '0;
    end else begin
      pin_q  <= pin;
      mode_q <= mode;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match
  import capcmp_pkg::*;
#(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic [TW-1:0] ccr,
  input  logic [2:0]    mode,
  output logic          match_hit
);
  logic eq, eq_q;

  assign eq        = mode_is_compare(mode) && (timer_val == ccr);
  assign match_hit = eq & ~eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end
endmodule

// File: rtl/capcmp_store.sv
module capcmp_store #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          cap_fire,
  input  logic          match_hit,
  input  logic          trig_mode,
  input  logic          irq_clr,
  output logic [TW-1:0] ccr_q,
  output logic          irq_flag,
  output logic          tmr_clr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q    <= '0;
      irq_flag <= 1'b0;
      tmr_clr  <= 1'b0;
    end else begin
      if (wr_en)         ccr_q <= wr_data;
      else if (cap_fire) ccr_q <= timer_val;
      if (cap_fire || match_hit) irq_flag <= 1'b1;
      else if (irq_clr)          irq_flag <= 1'b0;
      tmr_clr <= match_hit & trig_mode;
    end
  end
endmodule

// File: rtl/capcmp_top.sv
module capcmp_top
  import capcmp_pkg::*;
#(
  parameter int unsigned TW    = 16,
  parameter int unsigned DIV_A = 4,
  parameter int unsigned DIV_B = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_val,
  input  logic          cap_pin,
  input  logic [2:0]    mode,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_data,
  input  logic          irq_clr,
  output logic [TW-1:0] ccr_q,
  output logic          irq_flag,
  output logic          tmr_clr
);
  // Internal events, named for the checker.
  logic cap_fire;
  logic match_hit;
  logic trig_mode;

  assign trig_mode = (mode == CC_CMP_TRIG);

  capcmp_edge #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(cap_pin), .mode(mode), .cap_fire(cap_fire)
  );

  capcmp_match #(.TW(TW)) u_match (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .ccr(ccr_q),
    .mode(mode), .match_hit(match_hit)
  );

  capcmp_store #(.TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .wr_en(wr_en),
    .wr_data(wr_data), .cap_fire(cap_fire), .match_hit(match_hit),
    .trig_mode(trig_mode), .irq_clr(irq_clr), .ccr_q(ccr_q),
    .irq_flag(irq_flag), .tmr_clr(tmr_clr)
  );
endmodule

// File: rtl/capcmp_chk.sv
module capcmp_chk #(
  parameter int unsigned TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] timer_val,
  input logic [2:0]    mode,
  input logic          wr_en,
  input logic [TW-1:0] wr_data,
  input logic          irq_clr,
  input logic [TW-1:0] ccr_q,
  input logic          irq_flag,
  input logic          tmr_clr,
  input logic          cap_fire,
  input logic          match_hit
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_R1: assert (ccr_q == '0 && !irq_flag && !tmr_clr);
    end
  end

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && !wr_en) |=> (ccr_q == $past(timer_val) && irq_flag));

  assert_hit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> !match_hit);

  assert_hit_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |=> irq_flag);

  assert_clr_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> !tmr_clr);

  assert_clr_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |-> ($past(mode) == 3'd6 && irq_flag));

  assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ccr_q == $past(wr_data)));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 3'd0 || mode == 3'd7) && !wr_en) |=> ($stable(ccr_q) && !tmr_clr));
endmodule

bind capcmp_top capcmp_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .mode(mode),
  .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr), .ccr_q(ccr_q),
  .irq_flag(irq_flag), .tmr_clr(tmr_clr), .cap_fire(cap_fire),
  .match_hit(match_hit)
);

// File: tb/capcmp_top_tb.sv
module capcmp_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timer_val = '0;
  logic        cap_pin = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_clr = 1'b0;
  logic [15:0] ccr_q;
  logic        irq_flag;
  logic        tmr_clr;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference state
  logic [15:0] m_ccr = '0;
  logic        m_irq = 1'b0, m_tclr = 1'b0, m_pin = 1'b0, m_eq = 1'b0;
  logic [2:0]  m_mode = 3'd0;
  int          m_rises = 0;
  logic [15:0] rnd_tmr = '0;

  always #2 clk = ~clk;  // 250 MHz

  capcmp_top u_dut (
    .clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_pin(cap_pin),
    .mode(mode), .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr),
    .ccr_q(ccr_q), .irq_flag(irq_flag), .tmr_clr(tmr_clr)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer than 100000", cycles);
      summary();
      $finish;
    end
  end

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string cap_tag(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd0, 3'd7: return "R10";
      default: return "R8";
    endcase
  endfunction

  function automatic int divisor_of(input logic [2:0] m);
    return (m == 3'd3) ? 4 : (m == 3'd4) ? 16 : 1;
  endfunction

  // One clock: drive at negedge, predict, wait an edge, compare at negedge.
  task automatic step(input logic p, input logic [2:0] md, input logic [15:0] tv,
                      input logic we, input logic [15:0] wd, input logic clr);
    logic  evt, cap, eq, hit;
    string rtag, itag;
    cap_pin = p; mode = md; timer_val = tv; wr_en = we; wr_data = wd; irq_clr = clr;
    evt = (md == 3'd1) ? (!p && m_pin) :
          (md >= 3'd2 && md <= 3'd4) ? (p && !m_pin) : 1'b0;
    if (md != m_mode) m_rises = 0;
    if (md == 3'd3 || md == 3'd4) begin
      if (evt) m_rises++;
      cap = evt && (m_rises % divisor_of(md) == 0);
    end else begin
      m_rises = 0;
      cap = evt;
    end
    eq  = (md == 3'd5 || md == 3'd6) && (tv == m_ccr);
    hit = eq && !m_eq;
    rtag = we ? "R8" : cap_tag(md);
    itag = hit ? "R6" : (we && cap) ? "R8" : "R9";
    if (we) m_ccr = wd;
    else if (cap) m_ccr = tv;
    if (cap || hit) m_irq = 1'b1;
    else if (clr) m_irq = 1'b0;
    m_tclr = hit && (md == 3'd6);
    m_pin = p; m_mode = md; m_eq = eq;
    @(posedge clk);
    @(negedge clk);
    check(rtag, "ccr_q", ccr_q, m_ccr);
    check(itag, "irq_flag", {15'd0, irq_flag}, {15'd0, m_irq});
    check("R7", "tmr_clr", {15'd0, tmr_clr}, {15'd0, m_tclr});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", "ccr_q in reset", ccr_q, 16'h0000);
    check("R1", "irq_flag in reset", {15'd0, irq_flag}, 16'h0);
    check("R1", "tmr_clr in reset", {15'd0, tmr_clr}, 16'h0);
    rst_n = 1'b1;

    // R3: rising edge capture
    step(0, 3'd2, 16'h1000, 0, 0, 0);
    step(1, 3'd2, 16'h1234, 0, 0, 0);
    step(1, 3'd2, 16'h1300, 0, 0, 1);
    // R2: falling edge capture
    step(0, 3'd1, 16'hBEEF, 0, 0, 0);
    step(1, 3'd1, 16'h0042, 0, 0, 1);
    // R4: every 4th rising edge
    for (int i = 0; i < 10; i++) begin
      step(1, 3'd3, 16'(16'h0200 + i), 0, 0, 1);
      step(0, 3'd3, 16'h0300, 0, 0, 1);
    end
    // R5: every 16th rising edge
    for (int i = 0; i < 18; i++) begin
      step(1, 3'd4, 16'(16'h0400 + i), 0, 0, 1);
      step(0, 3'd4, 16'h0500, 0, 0, 1);
    end
    // R6: compare match held for several cycles fires once
    step(0, 3'd5, 16'd0, 1, 16'd10, 1);
    for (int t = 7; t <= 10; t++) step(0, 3'd5, 16'(t), 0, 0, 1);
    step(0, 3'd5, 16'd10, 0, 0, 1);
    step(0, 3'd5, 16'd10, 0, 0, 0);
    // R7: special trigger strobe
    step(0, 3'd6, 16'd9, 0, 0, 1);
    step(0, 3'd6, 16'd10, 0, 0, 0);
    step(0, 3'd6, 16'd0, 0, 0, 0);
    // R8: write and capture in the same cycle
    step(0, 3'd2, 16'h7777, 0, 0, 1);
    step(1, 3'd2, 16'h8888, 1, 16'hA5A5, 0);
    // R9: match and clear in the same cycle
    step(0, 3'd5, 16'h0001, 0, 0, 1);
    step(0, 3'd5, 16'hA5A5, 0, 0, 1);
    // R10: off modes ignore pin and equality
    for (int i = 0; i < 6; i++) step(i[0], 3'd0, 16'hA5A5, 0, 0, 1);
    for (int i = 0; i < 6; i++) step(i[0], 3'd7, 16'(i), 0, 0, 1);

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0]  md;
      logic        p, we, clr;
      logic [15:0] wd;
      md  = ($urandom % 24 == 0) ? 3'($urandom % 8) : m_mode;
      p   = ($urandom % 3 == 0) ? ~m_pin : m_pin;
      we  = ($urandom % 16 == 0);
      wd  = 16'($urandom % 48);
      clr = ($urandom % 8 == 0);
      if (m_tclr) rnd_tmr = '0;
      else if ($urandom % 4 != 0) rnd_tmr = (rnd_tmr + 16'd1) & 16'h003F;
      step(p, md, rnd_tmr, we, wd, clr);
    end

    summary();
    $finish;
  end
endmodule